// File: doc/BRIEF.md
# Posted-Write Store Buffer with Bypass

This block sits between a processor's store path and a single-beat external bus. Writes that may be posted are placed in a small first-in first-out queue. The core is told at once that such a write is complete and goes on with its work. The bus then retires the queued entries one at a time, oldest first.

Two control bits decide how writes are handled, and a reset clears both. One bit enables posting. The other bit turns on default write protection. Each access also carries its own attributes: precise or imprecise, write-through, cache-inhibited, and a region-override flag.

A write that may not be posted goes to the bus directly. Before it is issued, every earlier queued entry must drain, so that the bus sees writes in program order. Such a write completes only when the bus acknowledges it. When protection is on and no region override applies, a write is refused with an access error and never reaches the bus.

Top module: `pwbuf_top`

## Requirements
- R1: The queue holds DEPTH (default 4) entries and issues them on the bus strictly in the order they were accepted.
- R2: With the posting-enable bit clear, every write goes straight to the bus. The core sees reqReady and rspDone only in the cycle the bus acknowledges that write.
- R3: With the posting-enable bit set, an imprecise write marked write-through or cache-inhibited is enqueued if the queue has room. reqReady and rspDone rise in the cycle the request is presented, before any bus acknowledge.
- R4: A precise write always bypasses the queue, whatever the enable bit holds. Its rspDone comes only in the cycle its own bus acknowledge arrives.
- R5: A bypassing write is not put on the bus until every earlier queued entry has been acknowledged.
- R6: While the queue is full, reqReady stays low for a postable write until an entry retires.
- R7: With the write-protect bit set and reqRegionHit low, the write gets rspErr with reqReady in the cycle it is presented. It gets no rspDone, produces no bus cycle and is not enqueued.
- R8: With reqRegionHit high, the write-protect bit has no effect on that access.
- R9: Reset clears both control bits, so after reset writes bypass the queue and none is refused.
- R10: busValid stays high with busAddr, busData and busBe unchanged until busAck. A queue entry is removed only on busAck.
- R11: A posting-enabled imprecise write marked neither write-through nor cache-inhibited bypasses the queue.
- R12: The control bits load from ctlBufEn and ctlWrProt in a cycle where ctlWrite is high, and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrite | input | 1 | Load strobe for the control bits |
| ctlBufEn | input | 1 | New value of the posting-enable bit |
| ctlWrProt | input | 1 | New value of the default write-protect bit |
| reqValid | input | 1 | Core write request present; held until reqReady |
| reqReady | output | 1 | Request consumed this cycle |
| reqAddr | input | AW | Write address |
| reqData | input | DW | Write data |
| reqBe | input | DW/8 | Byte enables |
| reqPrecise | input | 1 | Precise-mode access |
| reqWriteThru | input | 1 | Write-through attribute |
| reqInhibit | input | 1 | Cache-inhibited attribute |
| reqRegionHit | input | 1 | Region override; suppresses the default protection check |
| rspDone | output | 1 | Write completed, valid with reqReady |
| rspErr | output | 1 | Access error, valid with reqReady |
| busValid | output | 1 | Bus write request |
| busAddr | output | AW | Bus write address |
| busData | output | DW | Bus write data |
| busBe | output | DW/8 | Bus byte enables |
| busAck | input | 1 | Bus write acknowledge |

## Verification
The bench stalls the bus to fill the queue. A design that lets a fifth write through would overwrite the oldest entry or lose it, and a design that pops without an acknowledge would drop data. It then sends a precise write behind queued entries. A design that lets that write jump the queue shows up as an out-of-order bus log, and one that completes it early shows up as rspDone arriving before its acknowledge. Protection is tested with and without the region override, and reset is applied while both control bits are set. A design that blocks every write when protected, or that keeps its configuration through reset, misroutes or refuses those writes.

// File: rtl/pwbuf_pkg.sv
package pwbuf_pkg;
  // strobes from the control unit to the datapath
  typedef struct packed {
    logic push;       // enqueue the presented request
    logic pop;        // retire the queue head
    logic selBypass;  // drive the bus from the presented request
  } pwbufStrobe_t;
endpackage

// File: rtl/pwbuf_ctrl.sv
module pwbuf_ctrl
  import pwbuf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ctlWrite,
  input  logic         ctlBufEn,
  input  logic         ctlWrProt,
  input  logic         reqValid,
  input  logic         reqPrecise,
  input  logic         reqWriteThru,
  input  logic         reqInhibit,
  input  logic         reqRegionHit,
  input  logic         qFull,
  input  logic         qEmpty,
  input  logic         busAck,
  output logic         reqReady,
  output logic         rspDone,
  output logic         rspErr,
  output pwbufStrobe_t strb
);
  logic bufEnQ;
  logic wrProtQ;
  logic protFault;
  logic postable;
  logic wantPost;
  logic wantDirect;
  logic directDone;

  // control bits, cleared by reset (R9, R12)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufEnQ  <= 1'b0;
      wrProtQ <= 1'b0;
    end else if (ctlWrite) begin
      bufEnQ  <= ctlBufEn;
      wrProtQ <= ctlWrProt;
    end
  end

  always_comb begin
    protFault  = wrProtQ && !reqRegionHit;
    postable   = bufEnQ && !reqPrecise && (reqWriteThru || reqInhibit);
    wantPost   = reqValid && !protFault && postable;
    wantDirect = reqValid && !protFault && !postable;

    strb.push      = wantPost && !qFull;
    strb.selBypass = wantDirect && qEmpty;
    strb.pop       = busAck && !qEmpty;

    directDone = strb.selBypass && busAck;
    rspErr     = reqValid && protFault;
    rspDone    = strb.push || directDone;
    reqReady   = rspErr || rspDone;
  end

  // a precise write completes only together with a bus acknowledge
  assert_precise_on_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqPrecise && rspDone) |-> busAck);

  // a refused write never completes
  assert_prot_no_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && wrProtQ && !reqRegionHit) |-> !rspDone);

  // override always lets the write proceed
  assert_region_no_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqRegionHit) |-> !rspErr);
endmodule

// File: rtl/pwbuf_dpath.sv
module pwbuf_dpath
  import pwbuf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  pwbufStrobe_t  strb,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic [DW/8-1:0] reqBe,
  input  logic          busAck,
  output logic          qFull,
  output logic          qEmpty,
  output logic          busValid,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busData,
  output logic [DW/8-1:0] busBe
);
  localparam int BW = DW / 8;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

  logic [AW-1:0] memAddr [DEPTH];
  logic [DW-1:0] memData [DEPTH];
  logic [BW-1:0] memBe   [DEPTH];
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;
  logic [CW-1:0] count;

  // per-entry storage, written only at the tail
  for (genvar i = 0; i < DEPTH; i++) begin : gEntry
    always_ff @(posedge clk) begin
      if (strb.push && wrPtr == PW'(i)) begin
        memAddr[i] <= reqAddr;
        memData[i] <= reqData;
        memBe[i]   <= reqBe;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    qFull    = (count == FULLCNT);
    qEmpty   = (count == '0);
    busValid = !qEmpty || strb.selBypass;
    if (qEmpty) begin
      busAddr = reqAddr;
      busData = reqData;
      busBe   = reqBe;
    end else begin
      busAddr = memAddr[rdPtr];
      busData = memData[rdPtr];
      busBe   = memBe[rdPtr];
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (count != FULLCNT));

  assert_pop_on_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> (busAck && count != '0));

  assert_bypass_drained_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.selBypass |-> (count == '0));

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busAck) |=> (busValid && $stable(busAddr) && $stable(busData) && $stable(busBe)));
endmodule

// File: rtl/pwbuf_top.sv
module pwbuf_top
  import pwbuf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctlWrite,
  input  logic            ctlBufEn,
  input  logic            ctlWrProt,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [AW-1:0]   reqAddr,
  input  logic [DW-1:0]   reqData,
  input  logic [DW/8-1:0] reqBe,
  input  logic            reqPrecise,
  input  logic            reqWriteThru,
  input  logic            reqInhibit,
  input  logic            reqRegionHit,
  output logic            rspDone,
  output logic            rspErr,
  output logic            busValid,
  output logic [AW-1:0]   busAddr,
  output logic [DW-1:0]   busData,
  output logic [DW/8-1:0] busBe,
  input  logic            busAck
);
  pwbufStrobe_t strb;
  logic qFull;
  logic qEmpty;

  pwbuf_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .ctlWrite(ctlWrite), .ctlBufEn(ctlBufEn), .ctlWrProt(ctlWrProt),
    .reqValid(reqValid), .reqPrecise(reqPrecise), .reqWriteThru(reqWriteThru),
    .reqInhibit(reqInhibit), .reqRegionHit(reqRegionHit),
    .qFull(qFull), .qEmpty(qEmpty), .busAck(busAck),
    .reqReady(reqReady), .rspDone(rspDone), .rspErr(rspErr), .strb(strb)
  );

  pwbuf_dpath #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqData(reqData), .reqBe(reqBe), .busAck(busAck),
    .qFull(qFull), .qEmpty(qEmpty),
    .busValid(busValid), .busAddr(busAddr), .busData(busData), .busBe(busBe)
  );
endmodule

// File: tb/sim_pwbuf_top.sv
`timescale 1ns/1ps
module sim_pwbuf_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlWrite = 1'b0, ctlBufEn = 1'b0, ctlWrProt = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [31:0] reqAddr = '0, reqData = '0;
  logic [3:0]  reqBe = '0;
  logic reqPrecise = 1'b0, reqWriteThru = 1'b0, reqInhibit = 1'b0, reqRegionHit = 1'b0;
  logic rspDone, rspErr;
  logic busValid;
  logic [31:0] busAddr, busData;
  logic [3:0]  busBe;
  logic busAck = 1'b0;

  int checks = 0;
  int failures = 0;
  logic stall = 1'b0;
  int ackDelay = 1;
  int waitCnt = 0;
  int logN = 0;
  logic [31:0] logAddr [64];
  logic [31:0] logData [64];

  always #2.5 clk = ~clk;

  pwbuf_top u0 (
    .clk(clk), .rstN(rstN), .ctlWrite(ctlWrite), .ctlBufEn(ctlBufEn), .ctlWrProt(ctlWrProt),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqData(reqData), .reqBe(reqBe),
    .reqPrecise(reqPrecise), .reqWriteThru(reqWriteThru), .reqInhibit(reqInhibit),
    .reqRegionHit(reqRegionHit), .rspDone(rspDone), .rspErr(rspErr),
    .busValid(busValid), .busAddr(busAddr), .busData(busData), .busBe(busBe), .busAck(busAck)
  );

  // bus responder: one-cycle ack after ackDelay waiting cycles, logs each write
  always @(negedge clk) begin
    if (!rstN || busAck) begin
      busAck = 1'b0;
      waitCnt = 0;
    end else if (busValid && !stall) begin
      if (waitCnt >= ackDelay) begin
        busAck = 1'b1;
        if (logN < 64) begin
          logAddr[logN] = busAddr;
          logData[logN] = busData;
        end
        logN++;
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic setCtl(input logic en, input logic prot);
    @(negedge clk);
    ctlWrite = 1'b1; ctlBufEn = en; ctlWrProt = prot;
    @(negedge clk);
    ctlWrite = 1'b0; ctlBufEn = 1'b0; ctlWrProt = 1'b0;
  endtask

  task automatic startReq(input logic [31:0] a, input logic [31:0] d, input logic pre,
                          input logic wt, input logic ci, input logic reg_hit);
    @(negedge clk);
    reqAddr = a; reqData = d; reqBe = 4'hF;
    reqPrecise = pre; reqWriteThru = wt; reqInhibit = ci; reqRegionHit = reg_hit;
    reqValid = 1'b1;
  endtask

  task automatic finishReq(output int cyc, output logic gDone, output logic gErr);
    cyc = 0; gDone = 1'b0; gErr = 1'b0;
    while (1) begin
      #1;
      if (reqReady) begin
        gDone = rspDone; gErr = rspErr;
        break;
      end
      @(negedge clk);
      cyc++;
      if (cyc > 500) break;
    end
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #1;
      if (!busValid) break;
    end
  endtask

  task automatic testReset();
    #1;
    check(busValid == 1'b0, "R9 reset busValid", busValid, 0);
    check(rspDone == 1'b0 && rspErr == 1'b0, "R9 reset responses", {rspDone, rspErr}, 0);
  endtask

  task automatic testDirectDisabled();
    int cyc; logic dn, er; int base;
    base = logN; ackDelay = 3;
    startReq(32'h100, 32'hA1, 1'b0, 1'b1, 1'b0, 1'b0);
    finishReq(cyc, dn, er);
    check(cyc >= 3, "R2 waits for bus ack", cyc, 3);
    check(dn == 1'b1 && er == 1'b0, "R2 completion", {dn, er}, 2'b10);
    check(logN == base + 1 && logAddr[base] == 32'h100, "R2 bus write", logAddr[base], 32'h100);
    ackDelay = 1;
  endtask

  task automatic testPosted();
    int cyc; logic dn, er; int base;
    logic [31:0] firstA;
    setCtl(1'b1, 1'b0);
    base = logN; stall = 1'b1;
    for (int k = 0; k < 4; k++) begin
      startReq(32'h200 + 32'(k * 4), 32'hB0 + 32'(k), 1'b0, k[0], !k[0], 1'b0);
      finishReq(cyc, dn, er);
      check(cyc == 0 && dn == 1'b1, "R3 posted write completes at once", cyc, 0);
    end
    check(logN == base, "R3 nothing acknowledged yet", logN - base, 0);
    // bus holds the head while stalled
    @(negedge clk); #1; firstA = busAddr;
    repeat (3) @(negedge clk);
    #1;
    check(busValid && busAddr == firstA && firstA == 32'h200, "R10 head held while stalled", busAddr, 32'h200);
    // fifth write must wait while full
    startReq(32'h210, 32'hB4, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      #1;
      check(reqReady == 1'b0, "R6 full queue stalls core", reqReady, 0);
      @(negedge clk);
    end
    stall = 1'b0;
    finishReq(cyc, dn, er);
    check(dn == 1'b1 && logN >= base + 1, "R6 accepted after a retire", logN - base, 1);
    drain();
    check(logN == base + 5, "R1 all entries issued", logN - base, 5);
    for (int k = 0; k < 5; k++)
      check(logAddr[base + k] == 32'h200 + 32'(k * 4) && logData[base + k] == 32'hB0 + 32'(k),
            "R1 FIFO order", logAddr[base + k], 32'h200 + 32'(k * 4));
  endtask

  task automatic testPreciseOrder();
    int cyc; logic dn, er; int base;
    base = logN; stall = 1'b1;
    startReq(32'h300, 32'hC0, 1'b0, 1'b0, 1'b1, 1'b0); finishReq(cyc, dn, er);
    startReq(32'h304, 32'hC1, 1'b0, 1'b0, 1'b1, 1'b0); finishReq(cyc, dn, er);
    startReq(32'h308, 32'hC2, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      #1;
      check(reqReady == 1'b0 && busAddr == 32'h300, "R5 precise write waits behind queue", busAddr, 32'h300);
      @(negedge clk);
    end
    stall = 1'b0;
    finishReq(cyc, dn, er);
    check(dn == 1'b1 && logN == base + 3, "R4 precise done with its ack", logN - base, 3);
    check(logAddr[base] == 32'h300 && logAddr[base + 1] == 32'h304 && logAddr[base + 2] == 32'h308,
          "R5 program order on bus", logAddr[base + 2], 32'h308);
    drain();
  endtask

  task automatic testOtherAttr();
    int cyc; logic dn, er; int base;
    base = logN; ackDelay = 2;
    startReq(32'h400, 32'hD0, 1'b0, 1'b0, 1'b0, 1'b0);
    finishReq(cyc, dn, er);
    check(cyc >= 1 && dn == 1'b1 && logN == base + 1, "R11 non-postable write bypasses", cyc, 2);
    ackDelay = 1;
  endtask

  task automatic testProtect();
    int cyc; logic dn, er; int base;
    setCtl(1'b1, 1'b1);
    base = logN;
    startReq(32'h500, 32'hE0, 1'b0, 1'b1, 1'b0, 1'b0);
    finishReq(cyc, dn, er);
    check(cyc == 0 && er == 1'b1 && dn == 1'b0, "R7 protected write refused", {dn, er}, 2'b01);
    repeat (4) @(negedge clk);
    #1;
    check(busValid == 1'b0 && logN == base, "R7 no bus cycle", logN - base, 0);
    startReq(32'h504, 32'hE1, 1'b1, 1'b0, 1'b1, 1'b1);
    finishReq(cyc, dn, er);
    check(dn == 1'b1 && er == 1'b0 && logN == base + 1 && logAddr[base] == 32'h504,
          "R8 override allows write", logAddr[base], 32'h504);
    check(cyc >= 1, "R12 control bits hold (precise still bypasses)", cyc, 1);
  endtask

  task automatic testResetClears();
    int cyc; logic dn, er; int base;
    drain();
    doReset();
    base = logN; ackDelay = 2;
    startReq(32'h600, 32'hF0, 1'b0, 1'b0, 1'b1, 1'b0);
    finishReq(cyc, dn, er);
    check(er == 1'b0 && dn == 1'b1, "R9 protection off after reset", {dn, er}, 2'b10);
    check(cyc >= 1 && logN == base + 1, "R9 posting off after reset", cyc, 2);
    ackDelay = 1;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testDirectDisabled();
    testPosted();
    testPreciseOrder();
    testOtherAttr();
    testProtect();
    testResetClears();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule